// File: doc/BRIEF.md
# Signed Barrel Arithmetic Shifter

This unit carries out arithmetic shifts for a processor's execute stage. It has two modes. Single mode shifts one 16-bit register. Pair mode shifts a 32-bit value built from an even/odd register pair. The distance and direction come from a signed 6-bit count field. A positive count shifts left and a negative count shifts right. Every count from -32 to +31 has a defined result and defined flags, including counts that reach or pass the word width.

The caller presents the operand words, the raw count field and the mode, then pulses `start_i` for one cycle. On the next clock edge the unit registers the result words and the four condition flags (N, Z, V, C), and raises `done_o` for one cycle. The registered outputs keep their values until the next start. Instruction decode, operand fetch and register writeback are outside this block.

Top module: `arith_shift_unit`

## Requirements
- R1: The count field is read as a two's-complement value from -32 to +31. A count of zero returns the operand unchanged, with C=0 and V=0.
- R2: In single mode, a left shift by d (1..15) fills zeros from the right, and C is operand bit (16-d).
- R3: In single mode, a left shift by 16 or more gives a zero result. C is operand bit 0 when d is exactly 16, and 0 for any d of 17 or more.
- R4: In single mode, a right shift by n (1..15) fills the operand sign from the left, and C is operand bit (n-1).
- R5: In single mode, a right shift by 16 or more gives all sign bits, and C equals the operand sign.
- R6: In pair mode, the operand is {hi_word_i, lo_word_i}, with hi as the upper half. The result upper half goes to hi_res_o and the lower half to lo_res_o. In single mode the operand is hi_word_i, the result is on hi_res_o, and lo_res_o returns lo_word_i unchanged.
- R7: In pair mode, a left shift by d (1..31) fills zeros from the right, and C is operand bit (32-d).
- R8: In pair mode, a right shift by n (1..31) fills the sign from the left, and C is operand bit (n-1). A count of -32 gives all sign bits, with C equal to the operand sign.
- R9: N is the result sign. Z is set when the shifted result (16 or 32 bits) is zero. V is set when the result sign differs from the operand sign.
- R10: Results and flags load only on a clock edge where start_i is high, and otherwise hold their values. done_o is high in exactly the cycle after each start.
- R11: While reset is active, all result words, flags and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; captures the operation on this edge |
| pair_mode_i | input | 1 | 0 = single 16-bit shift, 1 = 32-bit pair shift |
| count_i | input | 6 | Signed shift count (+ left, - right) |
| hi_word_i | input | 16 | Single operand, or upper half of the pair |
| lo_word_i | input | 16 | Lower half of the pair |
| hi_res_o | output | 16 | Single result, or upper half of the pair result |
| lo_res_o | output | 16 | Lower half of the pair result; lo_word_i in single mode |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Sign-change flag |
| flag_c_o | output | 1 | Last bit shifted out |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse of one operation can fall in the same cycle as the capture of the next. This happens when start_i is held high on two consecutive edges. The bench provokes this case directly. In the overlap cycle it expects done_o to stay high, the first result to be visible, and the second result to replace it on the following edge without a gap. It then expects done_o to drop while the second result holds. Every count from -32 to +31 in both modes is compared against a bench model that widens the operand to 64 bits.

// File: rtl/asu_pkg.sv
package asu_pkg;
  localparam int unsigned ASU_WORD_W = 16;
  localparam int unsigned ASU_CNT_W  = 6;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } asu_flags_t;
endpackage

// File: rtl/asu_rst_sync.sv
module asu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/asu_shift_core.sv
module asu_shift_core #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 6
) (
  input  logic [W-1:0]     src,
  input  logic [CNT_W-1:0] cnt,
  output logic [W-1:0]     res,
  output logic             carry
);
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;

  logic             is_right;
  logic [CNT_W-1:0] mag;
  logic             sign;
  logic             past_width;
  logic [IDX_W-1:0] lidx;
  logic [IDX_W-1:0] ridx;

  // magnitude of the signed count; -2^(CNT_W-1) maps to 2^(CNT_W-1)
  assign is_right   = cnt[CNT_W-1];
  assign mag        = is_right ? (~cnt + 1'b1) : cnt;
  assign sign       = src[W-1];
  assign past_width = (32'(mag) >= W);
  assign lidx       = IDX_W'(W - 32'(mag));
  assign ridx       = IDX_W'(32'(mag) - 1);

  always_comb begin
    res   = src;
    carry = 1'b0;
    if (mag == '0) begin
      res   = src;
      carry = 1'b0;
    end else if (!is_right) begin
      if (past_width) begin
        res   = '0;
        carry = (32'(mag) == W) ? src[0] : 1'b0;
      end else begin
        res   = src << mag;
        carry = src[lidx];
      end
    end else begin
      if (past_width) begin
        res   = {W{sign}};
        carry = sign;
      end else begin
        res   = W'($signed(src) >>> mag);
        carry = src[ridx];
      end
    end
  end
endmodule

// File: rtl/asu_flag_gen.sv
module asu_flag_gen
  import asu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic             src_sign,
  input  logic [W-1:0]     res,
  input  logic             carry,
  output asu_flags_t       flags
);
  always_comb begin
    flags.n = res[W-1];
    flags.z = (res == '0);
    flags.v = res[W-1] ^ src_sign;
    flags.c = carry;
  end
endmodule

// File: rtl/arith_shift_unit.sv
module arith_shift_unit
  import asu_pkg::*;
#(
  parameter int unsigned WORD_W = ASU_WORD_W,
  parameter int unsigned CNT_W  = ASU_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pair_mode_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORD_W-1:0] hi_word_i,
  input  logic [WORD_W-1:0] lo_word_i,
  output logic [WORD_W-1:0] hi_res_o,
  output logic [WORD_W-1:0] lo_res_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o,
  output logic              done_o
);
  localparam int unsigned PAIR_W = 2 * WORD_W;

  logic rst_n_int;

  asu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // Two datapaths, one per operand width, chosen by a generate loop
  logic [WORD_W-1:0] s_res;
  logic              s_carry;
  asu_flags_t        s_flags;
  logic [PAIR_W-1:0] p_src;
  logic [PAIR_W-1:0] p_res;
  logic              p_carry;
  asu_flags_t        p_flags;

  assign p_src = {hi_word_i, lo_word_i};

  for (genvar g = 0; g < 2; g++) begin : g_path
    if (g == 0) begin : g_single
      asu_shift_core #(.W(WORD_W), .CNT_W(CNT_W)) u_core (
        .src   (hi_word_i),
        .cnt   (count_i),
        .res   (s_res),
        .carry (s_carry)
      );
      asu_flag_gen #(.W(WORD_W)) u_flags (
        .src_sign (hi_word_i[WORD_W-1]),
        .res      (s_res),
        .carry    (s_carry),
        .flags    (s_flags)
      );
    end else begin : g_pair
      asu_shift_core #(.W(PAIR_W), .CNT_W(CNT_W)) u_core (
        .src   (p_src),
        .cnt   (count_i),
        .res   (p_res),
        .carry (p_carry)
      );
      asu_flag_gen #(.W(PAIR_W)) u_flags (
        .src_sign (p_src[PAIR_W-1]),
        .res      (p_res),
        .carry    (p_carry),
        .flags    (p_flags)
      );
    end
  end

  // next-state
  logic [WORD_W-1:0] hi_d, lo_d, hi_q, lo_q;
  asu_flags_t        flags_d, flags_q;
  logic              load_en;
  logic              done_q;

  assign load_en = start_i;

  always_comb begin
    if (pair_mode_i) begin
      hi_d    = p_res[PAIR_W-1:WORD_W];
      lo_d    = p_res[WORD_W-1:0];
      flags_d = p_flags;
    end else begin
      hi_d    = s_res;
      lo_d    = lo_word_i;
      flags_d = s_flags;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      hi_q    <= '0;
      lo_q    <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= load_en;
      if (load_en) begin
        hi_q    <= hi_d;
        lo_q    <= lo_d;
        flags_q <= flags_d;
      end
    end
  end

  assign hi_res_o = hi_q;
  assign lo_res_o = lo_q;
  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_v_o = flags_q.v;
  assign flag_c_o = flags_q.c;
  assign done_o   = done_q;
endmodule

// File: rtl/asu_checker.sv
module asu_checker #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              pair_mode_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [WORD_W-1:0] hi_word_i,
  input logic [WORD_W-1:0] lo_word_i,
  input logic [WORD_W-1:0] hi_res_o,
  input logic [WORD_W-1:0] lo_res_o,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic              flag_v_o,
  input logic              flag_c_o,
  input logic              done_o
);
  AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o); // R10
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i)); // R10
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(hi_res_o) && $stable(lo_res_o) && $stable(flag_c_o))); // R10
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && count_i == '0) |=> (hi_res_o == $past(hi_word_i) && !flag_c_o)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && count_i == '0) |=> !flag_v_o); // R9
  AST_SINGLE_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !pair_mode_i) |=> (lo_res_o == $past(lo_word_i))); // R6
  AST_PAIR_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && flag_z_o && $past(pair_mode_i)) |-> (hi_res_o == '0 && lo_res_o == '0)); // R9
  AST_BIG_LEFT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !pair_mode_i && !count_i[CNT_W-1] && 32'(count_i) > WORD_W)
      |=> (hi_res_o == '0 && !flag_c_o)); // R3
endmodule

bind arith_shift_unit asu_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .pair_mode_i (pair_mode_i),
  .count_i     (count_i),
  .hi_word_i   (hi_word_i),
  .lo_word_i   (lo_word_i),
  .hi_res_o    (hi_res_o),
  .lo_res_o    (lo_res_o),
  .flag_n_o    (flag_n_o),
  .flag_z_o    (flag_z_o),
  .flag_v_o    (flag_v_o),
  .flag_c_o    (flag_c_o),
  .done_o      (done_o)
);

// File: tb/sim_arith_shift_unit.sv
`timescale 1ns/1ps
module sim_arith_shift_unit;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        pair_mode_i;
  logic [5:0]  count_i;
  logic [15:0] hi_word_i, lo_word_i;
  logic [15:0] hi_res_o, lo_res_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o, done_o;

  int checks = 0;
  int errs   = 0;
  bit finished = 0;

  arith_shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pair_mode_i(pair_mode_i),
    .count_i(count_i), .hi_word_i(hi_word_i), .lo_word_i(lo_word_i),
    .hi_res_o(hi_res_o), .lo_res_o(lo_res_o), .flag_n_o(flag_n_o),
    .flag_z_o(flag_z_o), .flag_v_o(flag_v_o), .flag_c_o(flag_c_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {pair, count, hi, lo, exp_hi, exp_lo, exp NZVC}
  localparam int NV = 13;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 6'h01, 16'h8000, 16'h1234, 16'h0000, 16'h1234, 4'b0111}, // R2 R9
    {1'b0, 6'h00, 16'h7FFF, 16'h1234, 16'h7FFF, 16'h1234, 4'b0000}, // R1
    {1'b0, 6'h10, 16'h0001, 16'h1234, 16'h0000, 16'h1234, 4'b0101}, // R3
    {1'b0, 6'h11, 16'h0001, 16'h1234, 16'h0000, 16'h1234, 4'b0100}, // R3
    {1'b0, 6'h3F, 16'h8000, 16'h1234, 16'hC000, 16'h1234, 4'b1000}, // R4
    {1'b0, 6'h30, 16'h8001, 16'h1234, 16'hFFFF, 16'h1234, 4'b1001}, // R5
    {1'b0, 6'h01, 16'h4000, 16'h1234, 16'h8000, 16'h1234, 4'b1010}, // R9
    {1'b0, 6'h3F, 16'h0003, 16'h1234, 16'h0001, 16'h1234, 4'b0001}, // R4
    {1'b1, 6'h01, 16'h0000, 16'h8000, 16'h0001, 16'h0000, 4'b0000}, // R6 R7
    {1'b1, 6'h20, 16'h8000, 16'h0000, 16'hFFFF, 16'hFFFF, 4'b1001}, // R8
    {1'b1, 6'h2F, 16'h0001, 16'h0000, 16'h0000, 16'h0000, 4'b0101}, // R8
    {1'b1, 6'h1F, 16'h4000, 16'h0001, 16'h8000, 16'h0000, 4'b1010}, // R7
    {1'b0, 6'h0F, 16'hFFFF, 16'h1234, 16'h8000, 16'h1234, 4'b1001}  // R2
  };
  localparam int VREQ [NV] = '{2, 1, 3, 3, 4, 5, 9, 4, 6, 8, 8, 7, 2};

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nzvc();
    return {flag_n_o, flag_z_o, flag_v_o, flag_c_o};
  endfunction

  // 64-bit wide model: result in [35:4], NZVC in [3:0]
  function automatic logic [35:0] model(input logic pair, input logic [5:0] c, input logic [15:0] h, input logic [15:0] l);
    int wd = pair ? 32 : 16;
    int k = int'($signed(c));
    logic [63:0] mask = (64'd1 << wd) - 64'd1;
    logic [63:0] s = pair ? {32'd0, h, l} : {48'd0, h};
    logic sg = s[wd-1];
    logic [63:0] w;
    logic [31:0] r;
    logic cy;
    if (k == 0) begin
      w = s; cy = 1'b0;
    end else if (k > 0) begin
      w = s << k; cy = w[wd];
    end else begin
      w = s | (sg ? ~mask : 64'd0);
      w = $signed(w) >>> (-k - 1);
      cy = w[0];
      w = $signed(w) >>> 1;
    end
    r = 32'(w & mask);
    return {r, r[wd-1], (r == 0), r[wd-1] ^ sg, cy};
  endfunction

  task automatic run_op(input logic pair, input logic [5:0] c, input logic [15:0] h, input logic [15:0] l);
    @(negedge clk);
    pair_mode_i = pair; count_i = c; hi_word_i = h; lo_word_i = l; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic sweep(input logic pair, input logic [15:0] h, input logic [15:0] l);
    for (int k = -32; k < 32; k++) begin
      logic [35:0] e;
      logic [35:0] a;
      string tag;
      e = model(pair, 6'(k), h, l);
      run_op(pair, 6'(k), h, l);
      if (pair) a = {hi_res_o, lo_res_o, nzvc()};
      else      a = {16'd0, hi_res_o, nzvc()};
      if (k == 0) tag = "R1 sweep";
      else if (pair) tag = (k > 0) ? "R7 sweep" : "R8 sweep";
      else if (k > 15) tag = "R3 sweep";
      else if (k > 0) tag = "R2 sweep";
      else if (k > -16) tag = "R4 sweep";
      else tag = "R5 sweep";
      chk(a == e && done_o, tag, a, e);
      if (!pair) chk(lo_res_o == l, "R6 single low", {20'd0, lo_res_o}, {20'd0, l});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog R10 actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; pair_mode_i = 1'b0; count_i = '0;
    hi_word_i = 16'h5A5A; lo_word_i = 16'hA5A5;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({hi_res_o, lo_res_o, nzvc(), done_o} == '0, "R11 reset", {hi_res_o, lo_res_o, nzvc()}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({hi_res_o, lo_res_o, nzvc(), done_o} == '0, "R11 after release", {hi_res_o, lo_res_o, nzvc()}, '0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [35:0] a;
      logic [35:0] e;
      run_op(VEC[i][74], VEC[i][73:68], VEC[i][67:52], VEC[i][51:36]);
      a = {hi_res_o, lo_res_o, nzvc()};
      e = VEC[i][35:0];
      chk(a == e, $sformatf("R%0d vector %0d", VREQ[i], i), a, e);
    end

    // exhaustive counts against the model
    sweep(1'b0, 16'h8000, 16'h0F0F);
    sweep(1'b0, 16'h7FFF, 16'h0000);
    sweep(1'b0, 16'h0000, 16'hFFFF);
    sweep(1'b0, 16'hFFFF, 16'h1111);
    sweep(1'b0, 16'h0001, 16'h2222);
    sweep(1'b1, 16'h8000, 16'h0000);
    sweep(1'b1, 16'h7FFF, 16'hFFFF);
    sweep(1'b1, 16'h0000, 16'h0000);
    sweep(1'b1, 16'hFFFF, 16'hFFFF);
    for (int r = 0; r < 3; r++) begin
      logic [15:0] rh, rl;
      rh = 16'($urandom); rl = 16'($urandom);
      sweep(1'b0, rh, rl);
      sweep(1'b1, rh, rl);
    end

    // R10 back-to-back starts: done of op1 coincides with capture of op2
    @(negedge clk);
    pair_mode_i = 1'b0; count_i = 6'h04; hi_word_i = 16'h0123; lo_word_i = 16'h0; start_i = 1'b1;
    @(negedge clk);
    chk(hi_res_o == 16'h1230 && done_o, "R10 overlap first", {19'd0, done_o, hi_res_o}, {19'd1, 16'h1230});
    pair_mode_i = 1'b1; count_i = 6'h3C; hi_word_i = 16'hF000; lo_word_i = 16'h0010;
    @(negedge clk);
    start_i = 1'b0;
    chk({hi_res_o, lo_res_o} == 32'hFF000001 && done_o, "R10 overlap second",
        {3'd0, done_o, hi_res_o, lo_res_o}, {4'd1, 32'hFF000001});
    hi_word_i = 16'h1357; lo_word_i = 16'h2468; count_i = 6'h02; pair_mode_i = 1'b0;
    @(negedge clk);
    chk(!done_o, "R10 done single cycle", {35'd0, done_o}, 36'd0);
    repeat (3) @(negedge clk);
    chk({hi_res_o, lo_res_o} == 32'hFF000001, "R10 hold without start",
        {4'd0, hi_res_o, lo_res_o}, {4'd0, 32'hFF000001});

    // R11 asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #2 chk({hi_res_o, lo_res_o, nzvc(), done_o} == '0, "R11 async clear",
           {hi_res_o, lo_res_o, nzvc()}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule